// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block sits between a set of interrupt-capable devices and a processor core. Each device presents a ready flag, an interrupt-enable flag and a three-bit urgency level. A device is asking for service only when it is both ready and enabled. The arbiter finds the most urgent of those requests and compares its level against the level the processor is running at. It raises the interrupt line only when the request is strictly more urgent than the running program.

The decision is registered only on cycles where the core flags an instruction boundary, the point between finishing one instruction and fetching the next. Between boundaries the outputs hold still, so the core always sees a stable request when it looks. The winning device index and level are reported next to the interrupt line. Vectoring, context saving and the handler itself belong to other blocks.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A device counts as requesting only when its `dev_ready` bit and its `dev_ien` bit are both 1. A device with only one of the two set never wins and never raises `irq`.
- R2: Urgency levels run from 0 (least urgent) to 7 (most urgent). Device i takes its level from `dev_level[3*i+2 : 3*i]`.
- R3: Among the requesting devices, the one with the numerically largest level is selected.
- R4: When several requesting devices share the largest level, the one with the lowest device index is selected.
- R5: `irq` is raised only when the selected level is strictly greater than `cpu_level`. A selected level equal to or below `cpu_level` leaves `irq` at 0.
- R6: `irq_dev` and `irq_level` report the selected device and its level whenever any device is requesting, whether or not `irq` is raised.
- R7: With no requesting device, a boundary update gives `irq` = 0, `irq_dev` = 0 and `irq_level` = 0.
- R8: The outputs load the new decision on the first rising clock edge where `boundary` is 1, and hold their values on every edge where `boundary` is 0.
- R9: While `rst` is high, `irq`, `irq_dev` and `irq_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_ready | input | NUM_DEV | Per-device ready flag |
| dev_ien | input | NUM_DEV | Per-device interrupt enable |
| dev_level | input | 3*NUM_DEV | Per-device urgency level, 3 bits each |
| cpu_level | input | 3 | Urgency level of the running program |
| boundary | input | 1 | Instruction-boundary strobe |
| irq | output | 1 | Interrupt request to the core |
| irq_dev | output | IDX_W | Index of the selected device |
| irq_level | output | 3 | Level of the selected device |

## Verification
The assertions watch several properties on every cycle: outputs hold between boundaries, a raised `irq` always carries a level above the `cpu_level` sampled at the boundary, the reported device was actually ready and enabled, and an empty request set clears all outputs. Ranking is different. Choosing the largest level and breaking ties toward the lowest index depend on comparing all requesters against each other, so only the bench's sweeps show them. The bench runs pseudo-random patterns against every processor level, plus directed ties, equal-level cases and half-enabled devices.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    // One contender: whether it is asking, and how urgently.
    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } cand_t;

    // True when c should replace the running best. Strictly-greater keeps
    // the earlier (lower index) contender on a tie.
    function automatic logic outranks(cand_t c, cand_t best);
        return c.hit && (!best.hit || (c.lvl > best.lvl));
    endfunction

    function automatic logic preempts(cand_t best, lvl_t cpu);
        return best.hit && (best.lvl > cpu);
    endfunction

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate
    import irq_arb_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic [NUM_DEV-1:0]       ready,
    input  logic [NUM_DEV-1:0]       ien,
    input  logic [NUM_DEV*LVL_W-1:0] level_flat,
    output cand_t                    cand [NUM_DEV]
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign cand[g] = '{hit: ready[g] & ien[g],
                           lvl: level_flat[g*LVL_W +: LVL_W]};
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter int IDX_W   = 3
) (
    input  cand_t              cand [NUM_DEV],
    output cand_t              best,
    output logic [IDX_W-1:0]   best_idx
);

    always_comb begin
        best     = '0;
        best_idx = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (outranks(cand[i], best)) begin
                best     = cand[i];
                best_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
    import irq_arb_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  cand_t            best,
    input  logic [IDX_W-1:0] best_idx,
    input  lvl_t             cpu_level,
    output logic             irq,
    output logic [IDX_W-1:0] irq_dev,
    output lvl_t             irq_level
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            irq_dev   <= '0;
            irq_level <= '0;
        end else if (boundary) begin
            irq       <= preempts(best, cpu_level);
            irq_dev   <= best_idx;
            irq_level <= best.hit ? best.lvl : '0;
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_DEV-1:0]       dev_ready,
    input  logic [NUM_DEV-1:0]       dev_ien,
    input  logic [NUM_DEV*LVL_W-1:0] dev_level,
    input  logic [LVL_W-1:0]         cpu_level,
    input  logic                     boundary,
    output logic                     irq,
    output logic [IDX_W-1:0]         irq_dev,
    output logic [LVL_W-1:0]         irq_level
);

    cand_t            cand [NUM_DEV];
    cand_t            best;
    logic [IDX_W-1:0] best_idx;

    irq_req_gate #(.NUM_DEV(NUM_DEV)) u_gate (
        .ready      (dev_ready),
        .ien        (dev_ien),
        .level_flat (dev_level),
        .cand       (cand)
    );

    irq_prio_pick #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_pick (
        .cand     (cand),
        .best     (best),
        .best_idx (best_idx)
    );

    irq_out_reg #(.IDX_W(IDX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .best      (best),
        .best_idx  (best_idx),
        .cpu_level (cpu_level),
        .irq       (irq),
        .irq_dev   (irq_dev),
        .irq_level (irq_level)
    );

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
    parameter int NUM_DEV = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DEV-1:0] dev_ready,
    input logic [NUM_DEV-1:0] dev_ien,
    input logic [2:0]         cpu_level,
    input logic               boundary,
    input logic               irq,
    input logic [IDX_W-1:0]   irq_dev,
    input logic [2:0]         irq_level
);

    logic [NUM_DEV-1:0] req;
    logic [NUM_DEV-1:0] one_hot_lsb;
    assign req         = dev_ready & dev_ien;
    assign one_hot_lsb = NUM_DEV'(1);

    // R8
    hold_between_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable({irq, irq_dev, irq_level}));

    // R5
    irq_above_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (!irq || (irq_level > $past(cpu_level))));

    // R1
    irq_source_live_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (!irq || ((($past(req) >> irq_dev) & one_hot_lsb) != '0)));

    // R7
    idle_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && (req == '0)) |=> (!irq && (irq_dev == '0) && (irq_level == '0)));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dev_ready (dev_ready),
    .dev_ien   (dev_ien),
    .cpu_level (cpu_level),
    .boundary  (boundary),
    .irq       (irq),
    .irq_dev   (irq_dev),
    .irq_level (irq_level)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  dev_ready = '0;
    logic [N-1:0]  dev_ien = '0;
    logic [3*N-1:0] dev_level = '0;
    logic [2:0]    cpu_level = '0;
    logic          boundary = 1'b0;
    logic          irq;
    logic [IW-1:0] irq_dev;
    logic [2:0]    irq_level;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter #(.NUM_DEV(N)) u_irq_prio_arbiter (
        .clk(clk), .rst(rst), .dev_ready(dev_ready), .dev_ien(dev_ien),
        .dev_level(dev_level), .cpu_level(cpu_level), .boundary(boundary),
        .irq(irq), .irq_dev(irq_dev), .irq_level(irq_level)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected outcome straight from R1..R7.
    task automatic expect_out(output int e_irq, output int e_dev, output int e_lvl);
        int found = 0;
        e_dev = 0; e_lvl = 0;
        for (int j = 0; j < N; j++) begin
            int lv = int'(dev_level[3*j +: 3]);
            if (dev_ready[j] && dev_ien[j] && (found == 0 || lv > e_lvl)) begin
                found = 1; e_dev = j; e_lvl = lv;
            end
        end
        e_irq = (found != 0 && e_lvl > int'(cpu_level)) ? 1 : 0;
    endtask

    // Drive at negedge with boundary high, sample at the next negedge.
    task automatic apply_and_check(input string tag);
        int e_irq, e_dev, e_lvl;
        boundary = 1'b1;
        expect_out(e_irq, e_dev, e_lvl);
        @(negedge clk);
        boundary = 1'b0;
        check({tag, " irq"},   int'(irq),       e_irq);
        check({tag, " dev"},   int'(irq_dev),   e_dev);
        check({tag, " level"}, int'(irq_level), e_lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;

        // R9 reset state, even with a boundary and live requests
        dev_ready = '1; dev_ien = '1; dev_level = {N{3'd7}}; boundary = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 irq", int'(irq), 0);
        check("R9 dev", int'(irq_dev), 0);
        check("R9 level", int'(irq_level), 0);
        rst = 1'b0; boundary = 1'b0;
        @(negedge clk);

        // R7 nothing pending
        dev_ready = '0; dev_ien = '0; cpu_level = 3'd0;
        apply_and_check("R7 idle");

        // R1 ready without enable, enable without ready, per device
        for (int d = 0; d < N; d++) begin
            dev_level = '0; dev_level[3*d +: 3] = 3'd6; cpu_level = 3'd1;
            dev_ready = '0; dev_ien = '0; dev_ready[d] = 1'b1;
            apply_and_check("R1 ready only");
            dev_ready = '0; dev_ien[d] = 1'b1;
            apply_and_check("R1 ien only");
            dev_ready[d] = 1'b1;
            apply_and_check("R1 R2 both");
        end

        // R4 all at same level: index 0 wins; then drop the low ones
        dev_level = {N{3'd5}}; dev_ien = '1; cpu_level = 3'd2;
        for (int d = 0; d < N; d++) begin
            dev_ready = '1 << d;
            apply_and_check("R4 tie");
        end

        // R5 equal level is not forwarded, R6 still reports it
        dev_ready = 8'b0001_0000; dev_ien = '1; dev_level = '0;
        dev_level[3*4 +: 3] = 3'd4; cpu_level = 3'd4;
        apply_and_check("R5 R6 equal");
        cpu_level = 3'd3;
        apply_and_check("R5 one above");
        cpu_level = 3'd7;
        dev_level[3*4 +: 3] = 3'd7;
        apply_and_check("R5 top blocked");

        // R8 hold: load a decision, then change inputs with boundary low
        dev_ready = 8'b1000_0000; dev_level[3*7 +: 3] = 3'd3; cpu_level = 3'd0;
        apply_and_check("R8 load");
        dev_ready = '0; cpu_level = 3'd7;
        repeat (3) @(negedge clk);
        check("R8 hold irq", int'(irq), 1);
        check("R8 hold dev", int'(irq_dev), 7);
        check("R8 hold level", int'(irq_level), 3);

        // R3 R5 sweep: pseudo-random patterns against every cpu level
        for (int p = 0; p < 600; p++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            dev_ready = lfsr[7:0] | lfsr[15:8];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            dev_ien = lfsr[23:16] | lfsr[7:0];
            dev_level = {lfsr[23:0]} ^ {8{lfsr[31:29]}};
            cpu_level = 3'(p % 8);
            apply_and_check("R3 sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule